// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the source-side state for a set of interrupt inputs and turns input activity into presentations for a downstream presenter. Before a source can do anything, it is given a kind exactly once: edge (message-style) or level. After that, a configuration port gives it a target server, a priority and a saved priority. A priority of all ones means the source is masked. Each presentation carries a global interrupt number, equal to `BASE` plus the local index, together with the source's server, priority and saved priority.

The presenter answers over plain pulse inputs. A reject hands an interrupt back to the source. An end-of-interrupt (EOI) retires it. A resend request starts a sequential walk over all sources, and each source gets a chance to present again. Edge sources keep two bits: a masked-pending bit and a rejected bit. Level sources keep an asserted bit and a sent bit. A level source replays only on a check event, which is an input change, a configuration write or a resend visit. A reject or EOI alone never makes a level source present again.

Presentations leave through a valid/ready stream with a single output register. Once `pres_valid` is high, the number, priority, server and saved priority stay stable until a cycle with `pres_ready` high. While the stream is back-pressured, the requests waiting behind it are held as one bit per source, so repeated events on the same source merge into one. A queued source is served in ascending index order. A new presentation loads in the same cycle the previous one is taken. The synchronous `state_clr` input restores every source to its post-reset state but keeps the kinds that were assigned. Only `rst_n` clears the kinds.

Top module: `irq_src_ctrl`

## Requirements
- R1: After `rst_n` or a `state_clr` cycle, `pres_valid`, `resend_busy` and `type_err` are 0, every priority is 0xFF (masked), and all status bits are clear. `state_clr` keeps the kinds already assigned.
- R2: A presentation of source i carries number `BASE`+i. Reject and EOI numbers are mapped back to an index by subtracting `BASE`. A number outside `BASE` to `BASE`+NUM_SRC-1 has no effect.
- R3: On an unmasked edge source, a rising input queues one presentation at the source's server and priority. On a masked edge source, a rising input sets masked-pending instead. A falling input does nothing.
- R4: A configuration write with a priority other than 0xFF, made to an edge source whose masked-pending bit is set, clears that bit and queues exactly one presentation.
- R5: A level source (`type_wr_level`=1) queues a presentation only when it is unmasked, asserted and not yet sent, and queuing it sets sent. While sent stays set, the source makes no further presentation.
- R6: A reject of an edge source sets its rejected bit. A resend visit clears the bit and queues a presentation only if the source is unmasked.
- R7: A reject or EOI of a level source clears its sent bit without presenting. The next check event presents the source again if it is still asserted and unmasked.
- R8: An EOI to an edge source changes neither its rejected bit nor its masked-pending bit.
- R9: An accepted `resend_req` raises `resend_busy` at the next clock edge. `resend_busy` stays high for exactly NUM_SRC cycles, visiting source i in the cycle that is i+1 edges after acceptance. A `resend_req` that arrives while `resend_busy` is high is ignored.
- R10: The first kind write to a source takes effect. A later write to the same source leaves the kind unchanged and makes `type_err` high for one cycle, one edge after the write. A source with no kind never presents.
- R11: While `pres_valid` is high and `pres_ready` is low, all presentation fields hold. Queued sources are served lowest index first, back to back.
- R12: A configuration write of 0xFF to a source that is queued but not yet loaded withdraws the request. An edge source records masked-pending, and a level source clears sent. A presentation never carries priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears kinds too |
| state_clr | input | 1 | Synchronous state restore that keeps kinds |
| src_in | input | NUM_SRC | Raw interrupt inputs, one per source |
| type_wr_en | input | 1 | Kind assignment strobe |
| type_wr_idx | input | IDX_W | Source index for the kind assignment |
| type_wr_level | input | 1 | 1 = level source, 0 = edge source |
| type_err | output | 1 | One-cycle pulse: the source already had a kind |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | IDX_W | Source index for the configuration write |
| cfg_wr_server | input | SRV_W | Target server |
| cfg_wr_prio | input | PRIO_W | Priority, all ones = masked |
| cfg_wr_saved | input | PRIO_W | Saved priority |
| pres_valid | output | 1 | Presentation available |
| pres_ready | input | 1 | Presenter takes the presentation |
| pres_num | output | NUM_W | Global interrupt number |
| pres_prio | output | PRIO_W | Priority of the presented source |
| pres_server | output | SRV_W | Server of the presented source |
| pres_saved | output | PRIO_W | Saved priority of the presented source |
| rej_valid | input | 1 | Reject strobe from the presenter |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | EOI strobe from the presenter |
| eoi_num | input | NUM_W | Global number being retired |
| resend_req | input | 1 | Start a resend walk |
| resend_busy | output | 1 | Resend walk in progress |

## Verification
An input edge, or a config, reject or EOI strobe, is registered into the per-source request bit at the first clock edge. The output register loads at the second edge, so the bench drives on falling edges and checks `pres_valid` and its fields at the second falling edge after the stimulus. During a resend walk, source i is visited i+1 edges after acceptance and reaches the output one edge later. The bench therefore counts the falling edges on which `resend_busy` is high, which must equal NUM_SRC, and checks the output only after the walk has ended. `type_err` is sampled at the first falling edge after the kind write. Checks that a stimulus has no effect wait the same two edges and then look for an idle output.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic {
    SRC_EDGE  = 1'b0,
    SRC_LEVEL = 1'b1
  } src_kind_e;

  // per-source event strobes, all for the current cycle
  typedef struct packed {
    logic grant;  // request taken by the output stage
    logic rej;    // presenter handed it back
    logic eoi;    // presenter retired it
    logic cfg;    // configuration write
    logic scan;   // resend walk visits it
  } src_evt_t;

endpackage

// File: rtl/isc_src_cell.sv
module isc_src_cell
  import isc_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              typed,
  input  src_kind_e         kind,
  input  logic              in_lvl,
  input  src_evt_t          evt,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved,
  input  logic [SRV_W-1:0]  cfg_srv,
  output logic [PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0] saved,
  output logic [SRV_W-1:0]  srv,
  output logic              want
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
  logic [SRV_W-1:0]  srv_q, srv_n;
  logic mpend_q, mpend_n, rej_q, rej_n;
  logic asrt_q, asrt_n, sent_q, sent_n;
  logic want_q, want_n;
  logic in_q;
  logic rise, masked_n, lvl_evt;

  assign rise = in_lvl & ~in_q;

  always_comb begin
    prio_n  = evt.cfg ? cfg_prio  : prio_q;
    saved_n = evt.cfg ? cfg_saved : saved_q;
    srv_n   = evt.cfg ? cfg_srv   : srv_q;
    mpend_n = mpend_q;
    rej_n   = rej_q;
    asrt_n  = asrt_q;
    sent_n  = sent_q;
    want_n  = want_q;
    lvl_evt = 1'b0;
    masked_n = (prio_n == MASKED);

    if (evt.grant) want_n = 1'b0;

    if (typed) begin
      if (kind == SRC_EDGE) begin
        if (evt.rej) rej_n = 1'b1;
        if (rise) begin
          if (masked_n) mpend_n = 1'b1;
          else          want_n  = 1'b1;
        end
        if (evt.cfg) begin
          if (masked_n) begin
            if (want_n) begin
              want_n  = 1'b0;
              mpend_n = 1'b1;
            end
          end else if (mpend_n) begin
            mpend_n = 1'b0;
            want_n  = 1'b1;
          end
        end
        if (evt.scan && rej_n) begin
          rej_n = 1'b0;
          if (!masked_n) want_n = 1'b1;
        end
      end else begin
        if (evt.rej || evt.eoi) sent_n = 1'b0;
        if (evt.cfg && masked_n && want_n) begin
          want_n = 1'b0;
          sent_n = 1'b0;
        end
        lvl_evt = (in_lvl != asrt_q) || evt.cfg || evt.scan;
        asrt_n  = in_lvl;
        if (lvl_evt && !masked_n && asrt_n && !sent_n) begin
          sent_n = 1'b1;
          want_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= MASKED;
      saved_q <= MASKED;
      srv_q   <= '0;
      mpend_q <= 1'b0;
      rej_q   <= 1'b0;
      asrt_q  <= 1'b0;
      sent_q  <= 1'b0;
      want_q  <= 1'b0;
      in_q    <= 1'b0;
    end else begin
      in_q <= in_lvl;
      if (clr) begin
        prio_q  <= MASKED;
        saved_q <= MASKED;
        srv_q   <= '0;
        mpend_q <= 1'b0;
        rej_q   <= 1'b0;
        asrt_q  <= 1'b0;
        sent_q  <= 1'b0;
        want_q  <= 1'b0;
      end else begin
        prio_q  <= prio_n;
        saved_q <= saved_n;
        srv_q   <= srv_n;
        mpend_q <= mpend_n;
        rej_q   <= rej_n;
        asrt_q  <= asrt_n;
        sent_q  <= sent_n;
        want_q  <= want_n;
      end
    end
  end

  assign prio  = prio_q;
  assign saved = saved_q;
  assign srv   = srv_q;
  assign want  = want_q;

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/isc_scan.sv
module isc_scan #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               start,
  output logic               busy,
  output logic [NUM_SRC-1:0] hit
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
    assign hit[g] = busy_q && (idx_q == IDX_W'(g));
  end

  assign busy = busy_q;

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  parameter int NUM_W   = 16,
  parameter int BASE    = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               state_clr,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               type_wr_en,
  input  logic [IDX_W-1:0]   type_wr_idx,
  input  logic               type_wr_level,
  output logic               type_err,
  input  logic               cfg_wr_en,
  input  logic [IDX_W-1:0]   cfg_wr_idx,
  input  logic [SRV_W-1:0]   cfg_wr_server,
  input  logic [PRIO_W-1:0]  cfg_wr_prio,
  input  logic [PRIO_W-1:0]  cfg_wr_saved,
  output logic               pres_valid,
  input  logic               pres_ready,
  output logic [NUM_W-1:0]   pres_num,
  output logic [PRIO_W-1:0]  pres_prio,
  output logic [SRV_W-1:0]   pres_server,
  output logic [PRIO_W-1:0]  pres_saved,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req,
  output logic               resend_busy
);

  localparam logic [NUM_W-1:0] BASE_NUM  = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] COUNT_NUM = NUM_W'(NUM_SRC);

  // ---------------- kind registers (cleared by rst_n only)
  logic [NUM_SRC-1:0] typed_q;
  src_kind_e          kind_q [NUM_SRC];
  logic               type_err_q;
  logic               type_ok;

  assign type_ok = type_wr_en && (int'(type_wr_idx) < NUM_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typed_q    <= '0;
      type_err_q <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) kind_q[i] <= SRC_EDGE;
    end else begin
      type_err_q <= type_ok && typed_q[type_wr_idx];
      if (type_ok && !typed_q[type_wr_idx]) begin
        typed_q[type_wr_idx] <= 1'b1;
        kind_q[type_wr_idx]  <= type_wr_level ? SRC_LEVEL : SRC_EDGE;
      end
    end
  end

  assign type_err = type_err_q;

  // ---------------- number decode for reject / EOI
  logic [NUM_W-1:0] rej_rel, eoi_rel;
  logic             rej_in, eoi_in;

  assign rej_rel = rej_num - BASE_NUM;
  assign eoi_rel = eoi_num - BASE_NUM;
  assign rej_in  = rej_valid && (rej_rel < COUNT_NUM);
  assign eoi_in  = eoi_valid && (eoi_rel < COUNT_NUM);

  // ---------------- resend walker
  logic [NUM_SRC-1:0] scan_hit;

  isc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_clr),
    .start (resend_req),
    .busy  (resend_busy),
    .hit   (scan_hit)
  );

  // ---------------- per-source state
  logic [NUM_SRC-1:0] want;
  logic [PRIO_W-1:0]  prio_a  [NUM_SRC];
  logic [PRIO_W-1:0]  saved_a [NUM_SRC];
  logic [SRV_W-1:0]   srv_a   [NUM_SRC];
  src_evt_t           evt     [NUM_SRC];

  logic             pick_any, load;
  logic [IDX_W-1:0] pick_idx;
  logic             out_v;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign evt[g].grant = load && (pick_idx == IDX_W'(g));
    assign evt[g].rej   = rej_in && (rej_rel == NUM_W'(g));
    assign evt[g].eoi   = eoi_in && (eoi_rel == NUM_W'(g));
    assign evt[g].cfg   = cfg_wr_en && (cfg_wr_idx == IDX_W'(g));
    assign evt[g].scan  = scan_hit[g];

    isc_src_cell #(.PRIO_W(PRIO_W), .SRV_W(SRV_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (state_clr),
      .typed     (typed_q[g]),
      .kind      (kind_q[g]),
      .in_lvl    (src_in[g]),
      .evt       (evt[g]),
      .cfg_prio  (cfg_wr_prio),
      .cfg_saved (cfg_wr_saved),
      .cfg_srv   (cfg_wr_server),
      .prio      (prio_a[g]),
      .saved     (saved_a[g]),
      .srv       (srv_a[g]),
      .want      (want[g])
    );
  end

  // ---------------- output stage
  isc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req (want),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign load = pick_any && (!out_v || pres_ready) && !state_clr;

  logic [NUM_W-1:0]  out_num;
  logic [PRIO_W-1:0] out_prio, out_saved;
  logic [SRV_W-1:0]  out_srv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v     <= 1'b0;
      out_num   <= '0;
      out_prio  <= '0;
      out_saved <= '0;
      out_srv   <= '0;
    end else if (state_clr) begin
      out_v <= 1'b0;
    end else if (load) begin
      out_v     <= 1'b1;
      out_num   <= BASE_NUM + NUM_W'(pick_idx);
      out_prio  <= prio_a[pick_idx];
      out_saved <= saved_a[pick_idx];
      out_srv   <= srv_a[pick_idx];
    end else if (pres_ready) begin
      out_v <= 1'b0;
    end
  end

  assign pres_valid  = out_v;
  assign pres_num    = out_num;
  assign pres_prio   = out_prio;
  assign pres_server = out_srv;
  assign pres_saved  = out_saved;

endmodule

// File: rtl/isc_chk.sv
module isc_chk #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  parameter int NUM_W   = 16,
  parameter int BASE    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              state_clr,
  input logic              type_wr_en,
  input logic              type_err,
  input logic              pres_valid,
  input logic              pres_ready,
  input logic [NUM_W-1:0]  pres_num,
  input logic [PRIO_W-1:0] pres_prio,
  input logic [SRV_W-1:0]  pres_server,
  input logic              resend_req,
  input logic              resend_busy
);

  AST_PRES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid && !pres_ready && !state_clr |=>
      pres_valid && $stable(pres_num) && $stable(pres_prio) && $stable(pres_server)); // R11

  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> ((pres_num - NUM_W'(BASE)) < NUM_W'(NUM_SRC))); // R2

  AST_NO_MASKED_PRES: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (pres_prio != '1)); // R12

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req && !resend_busy && !state_clr |=> resend_busy); // R9

  AST_TYPE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    type_err |-> $past(type_wr_en)); // R10

  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_clr |=> !pres_valid && !resend_busy && !type_err); // R1

endmodule

bind irq_src_ctrl isc_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)
) u_isc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state_clr   (state_clr),
  .type_wr_en  (type_wr_en),
  .type_err    (type_err),
  .pres_valid  (pres_valid),
  .pres_ready  (pres_ready),
  .pres_num    (pres_num),
  .pres_prio   (pres_prio),
  .pres_server (pres_server),
  .resend_req  (resend_req),
  .resend_busy (resend_busy)
);

// File: tb/test_irq_src_ctrl.sv
module test_irq_src_ctrl;
  localparam int N = 8, PW = 8, SW = 4, NW = 16, BASE = 32, IW = 3;

  logic clk, rst_n, state_clr;
  logic [N-1:0] src_in;
  logic type_wr_en, type_wr_level, type_err;
  logic [IW-1:0] type_wr_idx, cfg_wr_idx;
  logic cfg_wr_en;
  logic [SW-1:0] cfg_wr_server;
  logic [PW-1:0] cfg_wr_prio, cfg_wr_saved;
  logic pres_valid, pres_ready;
  logic [NW-1:0] pres_num;
  logic [PW-1:0] pres_prio, pres_saved;
  logic [SW-1:0] pres_server;
  logic rej_valid, eoi_valid, resend_req, resend_busy;
  logic [NW-1:0] rej_num, eoi_num;

  irq_src_ctrl #(.NUM_SRC(N), .PRIO_W(PW), .SRV_W(SW), .NUM_W(NW), .BASE(BASE)) i_irq_src_ctrl (
    .clk(clk), .rst_n(rst_n), .state_clr(state_clr), .src_in(src_in),
    .type_wr_en(type_wr_en), .type_wr_idx(type_wr_idx), .type_wr_level(type_wr_level),
    .type_err(type_err), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_server(cfg_wr_server), .cfg_wr_prio(cfg_wr_prio), .cfg_wr_saved(cfg_wr_saved),
    .pres_valid(pres_valid), .pres_ready(pres_ready), .pres_num(pres_num),
    .pres_prio(pres_prio), .pres_server(pres_server), .pres_saved(pres_saved),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req), .resend_busy(resend_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] prio_of(int i); return PW'(i + 1); endfunction
  function automatic logic [SW-1:0] srv_of(int i); return SW'((i * 3 + 1) % 16); endfunction
  function automatic logic [PW-1:0] saved_of(int i); return PW'(16 + i); endfunction

  task automatic tick; @(negedge clk); endtask

  task automatic expect_pres(input int i, input string tag);
    chk(pres_valid == 1'b1, {tag, " valid"}, 32'(pres_valid), 32'd1);
    chk(pres_num == NW'(BASE + i), {tag, " num"}, 32'(pres_num), 32'(BASE + i));
    chk(pres_prio == prio_of(i) && pres_server == srv_of(i) && pres_saved == saved_of(i),
        {tag, " prio/server/saved"}, {8'd0, pres_saved, pres_server, pres_prio[3:0], pres_prio},
        {8'd0, saved_of(i), srv_of(i), prio_of(i)[3:0], prio_of(i)});
  endtask

  task automatic expect_idle(input string tag);
    chk(pres_valid == 1'b0, tag, 32'(pres_valid), 32'd0);
  endtask

  task automatic take; pres_ready = 1'b1; tick; pres_ready = 1'b0; endtask

  task automatic cfg(input int i, input logic [PW-1:0] p);
    cfg_wr_en = 1'b1; cfg_wr_idx = IW'(i); cfg_wr_prio = p;
    cfg_wr_server = srv_of(i); cfg_wr_saved = saved_of(i);
    tick; cfg_wr_en = 1'b0;
  endtask

  task automatic rej(input int num);
    rej_valid = 1'b1; rej_num = NW'(num); tick; rej_valid = 1'b0;
  endtask

  task automatic eoi(input int num);
    eoi_valid = 1'b1; eoi_num = NW'(num); tick; eoi_valid = 1'b0;
  endtask

  task automatic resend_wait;
    resend_req = 1'b1; tick; resend_req = 1'b0;
    while (resend_busy) tick;
    tick;
  endtask

  task automatic set_type(input int i, input bit lvl);
    type_wr_en = 1'b1; type_wr_idx = IW'(i); type_wr_level = lvl; tick; type_wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary;
    $finish;
  end

  initial begin
    rst_n = 0; state_clr = 0; src_in = '0; type_wr_en = 0; type_wr_idx = '0; type_wr_level = 0;
    cfg_wr_en = 0; cfg_wr_idx = '0; cfg_wr_server = '0; cfg_wr_prio = '0; cfg_wr_saved = '0;
    pres_ready = 0; rej_valid = 0; rej_num = '0; eoi_valid = 0; eoi_num = '0; resend_req = 0;
    repeat (3) tick;
    rst_n = 1;
    tick;
    // R1 reset state
    chk(pres_valid == 0 && resend_busy == 0 && type_err == 0, "R1 reset outputs",
        {29'd0, pres_valid, resend_busy, type_err}, 32'd0);

    // R10 kinds: even = edge, odd = level, 6 and 7 stay untyped
    for (int i = 0; i < 6; i++) begin
      set_type(i, i[0]);
      chk(type_err == 0, "R10 first kind write", 32'(type_err), 32'd0);
    end
    set_type(0, 1'b1);
    chk(type_err == 1, "R10 second kind write flagged", 32'(type_err), 32'd1);
    tick;
    chk(type_err == 0, "R10 flag lasts one cycle", 32'(type_err), 32'd0);

    // R3 / R4 edge sweep
    for (int i = 0; i < 6; i += 2) begin
      src_in[i] = 1; tick; tick;
      expect_idle("R3 masked rise held back");
      cfg(i, prio_of(i)); tick;
      expect_pres(i, "R4 unmask replays pending");
      take;
      expect_idle("R4 single replay");
      src_in[i] = 0; tick; tick;
      expect_idle("R3 falling input ignored");
      src_in[i] = 1; tick; tick;
      expect_pres(i, "R3 unmasked rise");
      take; src_in[i] = 0; tick;
    end

    // R5 / R7 / R9 level sweep
    for (int i = 1; i < 6; i += 2) begin
      int cnt;
      cfg(i, prio_of(i)); tick;
      expect_idle("R5 not asserted");
      src_in[i] = 1; tick; tick;
      expect_pres(i, "R5 level present");
      take; repeat (3) tick;
      expect_idle("R5 sent blocks repeat");
      eoi(BASE + i); tick;
      expect_idle("R7 eoi alone no replay");
      resend_req = 1; tick; resend_req = 0;
      chk(resend_busy == 1, "R9 busy rises", 32'(resend_busy), 32'd1);
      cnt = 1;
      while (resend_busy) begin
        resend_req = (cnt == 3);
        tick;
        if (resend_busy) cnt++;
      end
      resend_req = 0;
      chk(cnt == N, "R9 busy length", 32'(cnt), 32'(N));
      expect_pres(i, "R7 resend replays level");
      take;
      expect_idle("R9 second request ignored");
      src_in[i] = 0; tick; eoi(BASE + i); tick;
    end

    // R6 edge reject
    src_in[0] = 1; tick; tick; expect_pres(0, "R6 setup"); take; src_in[0] = 0;
    rej(BASE + 0); resend_wait;
    expect_pres(0, "R6 rejected replayed on resend");
    take;
    rej(BASE + 0); cfg(0, 8'hFF); resend_wait;
    expect_idle("R6 masked not replayed");
    cfg(0, prio_of(0)); tick;
    expect_idle("R6 unmask after clear silent");
    resend_wait;
    expect_idle("R6 rejected bit consumed");

    // R7 level reject then config check event
    src_in[1] = 1; tick; tick; expect_pres(1, "R7 setup"); take;
    rej(BASE + 1); tick;
    expect_idle("R7 reject alone no replay");
    cfg(1, prio_of(1)); tick;
    expect_pres(1, "R7 config replays level");
    take; src_in[1] = 0; tick; eoi(BASE + 1);

    // R8 EOI on edge source
    src_in[2] = 1; tick; tick; expect_pres(2, "R8 setup"); take; src_in[2] = 0;
    rej(BASE + 2); eoi(BASE + 2); resend_wait;
    expect_pres(2, "R8 eoi kept rejected bit");
    take;
    eoi(BASE + 4); resend_wait;
    expect_idle("R8 eoi on idle edge");

    // R2 out-of-range numbers
    src_in[0] = 1; tick; tick; expect_pres(0, "R2 number of source 0"); take; src_in[0] = 0;
    rej(BASE - 1); rej(BASE + N); resend_wait;
    expect_idle("R2 out-of-range reject ignored");

    // R10 untyped source
    cfg(6, prio_of(6)); src_in[6] = 1; tick; tick;
    expect_idle("R10 untyped never presents");
    src_in[6] = 0; tick;

    // R11 ordering and hold
    src_in[0] = 1; src_in[2] = 1; src_in[4] = 1; tick; tick;
    expect_pres(0, "R11 lowest first");
    for (int k = 0; k < 3; k++) begin tick; expect_pres(0, "R11 hold under back-pressure"); end
    take; expect_pres(2, "R11 second");
    take; expect_pres(4, "R11 third");
    take; expect_idle("R11 drained");
    src_in = '0; tick;

    // R12 withdraw a queued request
    src_in[0] = 1; src_in[2] = 1; tick; tick;
    expect_pres(0, "R12 setup");
    cfg(2, 8'hFF);
    take;
    expect_idle("R12 masked request withdrawn");
    cfg(2, prio_of(2)); tick;
    expect_pres(2, "R12 withdrawn kept as pending");
    take; src_in = '0; tick;

    // R1 state clear keeps kinds
    src_in[1] = 1; cfg(1, prio_of(1));
    state_clr = 1; tick; state_clr = 0;
    chk(pres_valid == 0 && resend_busy == 0, "R1 clear idles outputs",
        {30'd0, pres_valid, resend_busy}, 32'd0);
    src_in[1] = 0; src_in[0] = 1; tick; tick;
    expect_idle("R1 clear masks sources");
    set_type(0, 1'b1);
    chk(type_err == 1, "R1 clear keeps kinds", 32'(type_err), 32'd1);
    cfg(0, prio_of(0)); tick;
    expect_pres(0, "R1 edge kind survives clear");
    take; src_in = '0; tick;

    summary;
    $finish;
  end
endmodule